// File: doc/BRIEF.md
# Serial Flash Configuration Reader

This block is the master side of a configuration load from an external serial flash. On a start request it pulls the flash chip select low. It then shifts a read opcode and a start address out on one output line. After that it captures the returned bitstream, either one bit per serial clock on a single input line or one nibble per serial clock on a four-line bus. The mode is chosen per transaction. Captured data is packed into bytes and offered on a valid/ready stream.

The serial clock comes from the system clock through an even divider. One of two divide ratios is picked per transaction by a clock-source select input, which stands for the internal-oscillator and user-clock choices. The command line changes after a falling serial-clock edge. Returned data is sampled at a falling edge, one full serial period after the flash launched it. When the stream consumer stalls, the serial clock is parked low, so the flash never runs ahead of the output. After the programmed number of bytes the chip select is released, the clock stops, and a one-cycle done pulse is given.

Top module: `as_cfg_reader`

## Requirements
- R1: While `rst_ni` is low, `cs_no` is 1, `sclk_o` is 0, `tvalid_o` is 0 and `done_o` is 0.
- R2: After an accepted start, `cs_no` goes low and `dq0_o` carries the opcode 0x03 followed by the 24-bit start address, MSB first, one bit per serial clock. The line changes only after falling edges of `sclk_o` and is stable at each rising edge.
- R3: `sclk_o` is low whenever `cs_no` is high. Each high phase of `sclk_o` lasts DIV_INT/2 system cycles when `clk_src_i` was 0 at start, and DIV_USR/2 system cycles when it was 1.
- R4: With `quad_i`=0 at start, data is taken from `dq_i[1]` only. One bit is taken per falling edge of `sclk_o`, beginning at the falling edge that ends serial cycle 33, and eight bits form a byte MSB first.
- R5: With `quad_i`=1 at start, `dq_i[3:0]` is taken as one nibble per falling edge, beginning at the same edge as in R4. Two nibbles form a byte, the first one being bits 7:4.
- R6: Mode, clock source, start address and byte count are latched at start. `start_i` and changes on those inputs have no effect while `cs_no` is low.
- R7: After `byte_count_i` bytes have been captured, `cs_no` returns high, `sclk_o` stays low, and `done_o` is high for exactly one cycle. Its high cycle falls on the cycle in which `cs_no` is already high. A count of 0 ends the transaction right after the command.
- R8: While `tvalid_o` is high and `tready_i` is low, `tvalid_o` and `tdata_o` hold, and a low `sclk_o` does not rise. Every captured byte is delivered in order and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a read transaction (taken only when idle) |
| quad_i | input | 1 | 1 selects four data lines, 0 selects one |
| clk_src_i | input | 1 | Serial clock ratio select: 0 DIV_INT, 1 DIV_USR |
| start_addr_i | input | ADDR_W | Flash start address |
| byte_count_i | input | CNT_W | Number of bytes to read |
| cs_no | output | 1 | Flash chip select, active low |
| sclk_o | output | 1 | Serial clock to the flash |
| dq0_o | output | 1 | Command and address output line |
| dq_i | input | 4 | Flash data lines |
| tdata_o | output | 8 | Stream byte |
| tvalid_o | output | 1 | Stream byte valid |
| tready_i | input | 1 | Stream consumer ready |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A wrong bit counter in the command shifter shows up in the shifted opcode and address within the first 32 serial clocks. A slip there also moves the first data sample, so every byte after it comes out with bits rotated. A packer counter out of step corrupts the very first byte delivered. A wrong remaining-byte count shows as a missing or extra byte, or as a misplaced done pulse, at the end of that same transaction. A stall path that lets the serial clock run gives a changed or lost byte at the first backpressure window longer than one byte time.

// File: rtl/as_cfg_pkg.sv
package as_cfg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DATA} rd_state_e;
  localparam logic [7:0] READ_OP = 8'h03;
endpackage

// File: rtl/as_sclk_gen.sv
module as_sclk_gen #(
  parameter int DIV_A = 4,
  parameter int DIV_B = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hold_i,
  input  logic sel_i,
  output logic sclk_o,
  output logic fall_o
);
  localparam int HALF_A = DIV_A / 2;
  localparam int HALF_B = DIV_B / 2;
  localparam int HMAX   = (HALF_A > HALF_B) ? HALF_A : HALF_B;
  localparam int CW     = (HMAX < 2) ? 1 : $clog2(HMAX);

  logic [CW-1:0] cnt_q, lim;
  logic          sclk_q, tick;

  assign lim    = sel_i ? CW'(HALF_B - 1) : CW'(HALF_A - 1);
  assign tick   = (cnt_q == lim);
  assign fall_o = run_i & sclk_q & tick;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!sclk_q && hold_i) begin
      cnt_q  <= cnt_q;  // park low under backpressure
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/as_cmd_shift.sv
module as_cmd_shift import as_cfg_pkg::*; #(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shift_i,
  output logic              dq0_o,
  output logic              last_o
);
  localparam int CMD_W = 8 + ADDR_W;
  localparam int BW    = $clog2(CMD_W);

  logic [CMD_W-1:0] sr_q;
  logic [BW-1:0]    bit_q;

  assign dq0_o  = sr_q[CMD_W-1];
  assign last_o = shift_i & (bit_q == BW'(CMD_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      bit_q <= '0;
    end else if (load_i) begin
      sr_q  <= {READ_OP, addr_i};
      bit_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {sr_q[CMD_W-2:0], 1'b0};
      bit_q <= bit_q + BW'(1);
    end
  end
endmodule

// File: rtl/as_byte_pack.sv
module as_byte_pack (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       smp_i,
  input  logic       quad_i,
  input  logic [3:0] dq_i,
  output logic [7:0] byte_o,
  output logic       done_o
);
  logic [7:0] acc_q, nxt;
  logic [2:0] cnt_q;

  assign nxt    = quad_i ? {acc_q[3:0], dq_i} : {acc_q[6:0], dq_i[1]};
  assign done_o = smp_i & (quad_i ? cnt_q[0] : (cnt_q == 3'd7));
  assign byte_o = nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (smp_i) begin
      acc_q <= nxt;
      cnt_q <= done_o ? 3'd0 : cnt_q + 3'd1;
    end
  end
endmodule

// File: rtl/as_cfg_reader.sv
module as_cfg_reader import as_cfg_pkg::*; #(
  parameter int ADDR_W  = 24,
  parameter int CNT_W   = 16,
  parameter int DIV_INT = 4,
  parameter int DIV_USR = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              quad_i,
  input  logic              clk_src_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  byte_count_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              dq0_o,
  input  logic [3:0]        dq_i,
  output logic [7:0]        tdata_o,
  output logic              tvalid_o,
  input  logic              tready_i,
  output logic              done_o
);
  rd_state_e        state_q;
  logic             quad_q, src_q, tvalid_q, done_q;
  logic [CNT_W-1:0] left_q;
  logic [7:0]       tdata_q, byte_val;
  logic             run, hold, fall, start_go, cmd_shift, cmd_last, smp, byte_done;

  assign run       = (state_q != ST_IDLE);
  assign hold      = tvalid_q & ~tready_i;
  assign start_go  = (state_q == ST_IDLE) & start_i;
  assign cmd_shift = fall & (state_q == ST_CMD);
  assign smp       = fall & (state_q == ST_DATA);

  as_sclk_gen #(.DIV_A(DIV_INT), .DIV_B(DIV_USR)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .hold_i (hold),
    .sel_i  (src_q),
    .sclk_o (sclk_o),
    .fall_o (fall)
  );

  as_cmd_shift #(.ADDR_W(ADDR_W)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_go),
    .addr_i  (start_addr_i),
    .shift_i (cmd_shift),
    .dq0_o   (dq0_o),
    .last_o  (cmd_last)
  );

  as_byte_pack u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_go),
    .smp_i  (smp),
    .quad_i (quad_q),
    .dq_i   (dq_i),
    .byte_o (byte_val),
    .done_o (byte_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      quad_q   <= 1'b0;
      src_q    <= 1'b0;
      left_q   <= '0;
      tdata_q  <= '0;
      tvalid_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tvalid_q && tready_i) tvalid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CMD;
          quad_q  <= quad_i;
          src_q   <= clk_src_i;
          left_q  <= byte_count_i;
        end
        ST_CMD: if (cmd_last) begin
          if (left_q == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (byte_done) begin
          // consumer slot is free here: rise is parked while it is full
          tdata_q  <= byte_val;
          tvalid_q <= 1'b1;
          left_q   <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no    = ~run;
  assign tdata_o  = tdata_q;
  assign tvalid_o = tvalid_q;
  assign done_o   = done_q;
endmodule

// File: rtl/as_cfg_reader_chk.sv
module as_cfg_reader_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_no,
  input logic       sclk_o,
  input logic       dq0_o,
  input logic [7:0] tdata_o,
  input logic       tvalid_o,
  input logic       tready_i,
  input logic       done_o
);
  p_sclk_idle_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  p_cmd_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $rose(sclk_o)) |-> $stable(dq0_o));

  p_done_cs_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_no);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvalid_o && !tready_i) |=> (tvalid_o && $stable(tdata_o)));

  p_hold_sclk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvalid_o && !tready_i && !sclk_o) |=> !sclk_o);
endmodule

bind as_cfg_reader as_cfg_reader_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_no    (cs_no),
  .sclk_o   (sclk_o),
  .dq0_o    (dq0_o),
  .tdata_o  (tdata_o),
  .tvalid_o (tvalid_o),
  .tready_i (tready_i),
  .done_o   (done_o)
);

// File: tb/as_cfg_reader_tb.sv
module as_cfg_reader_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, quad_i = 1'b0, clk_src_i = 1'b0;
  logic [23:0] start_addr_i = '0;
  logic [15:0] byte_count_i = '0;
  logic        cs_no, sclk_o, dq0_o, tvalid_o, done_o;
  logic [3:0]  dq_i = '0;
  logic [7:0]  tdata_o;
  logic        tready_i = 1'b1;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic        quad;
    logic        src;
    logic [23:0] addr;
    logic [7:0]  nb;
    logic [1:0]  rdy;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 24'h123456, 8'd5,  2'd0},
    '{1'b1, 1'b0, 24'hABCDEF, 8'd12, 2'd0},
    '{1'b0, 1'b1, 24'h00FF00, 8'd4,  2'd1},
    '{1'b1, 1'b1, 24'h800001, 8'd10, 2'd2},
    '{1'b1, 1'b0, 24'h7E5A3C, 8'd16, 2'd1},
    '{1'b0, 1'b0, 24'hFFFFFF, 8'd3,  2'd2}
  };

  always #2 clk = ~clk;

  as_cfg_reader u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .quad_i(quad_i),
    .clk_src_i(clk_src_i), .start_addr_i(start_addr_i), .byte_count_i(byte_count_i),
    .cs_no(cs_no), .sclk_o(sclk_o), .dq0_o(dq0_o), .dq_i(dq_i),
    .tdata_o(tdata_o), .tvalid_o(tvalid_o), .tready_i(tready_i), .done_o(done_o)
  );

  // model and monitor state
  logic        cur_quad = 1'b0;
  logic [23:0] cur_addr = '0;
  logic [1:0]  rdy_mode = 2'd0;
  int          exp_half = 2;
  int cyc = 0, falls = 0, ncap = 0, got = 0, done_cnt = 0, hi_len = 0, hi_bad = 0;
  logic [31:0] cmd_word = '0;
  logic pv = 1'b0, pr = 1'b0, psclk = 1'b0, phold = 1'b0;
  logic [7:0] pd = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [23:0] a, input int k);
    return a[7:0] ^ a[15:8] ^ 8'(k * 29 + 17);
  endfunction

  function automatic logic [3:0] unit_val(input logic q, input logic [23:0] a, input int j);
    logic [7:0] b;
    logic bt;
    if (q) begin
      b = fbyte(a, j / 2);
      return (j % 2 == 0) ? b[7:4] : b[3:0];
    end
    b  = fbyte(a, j / 8);
    bt = b[7 - (j % 8)];
    return {~bt, ~bt, bt, ~bt};  // R4: only line 1 carries data
  endfunction

  task automatic monitor();
    forever begin
      @(negedge clk);
      cyc++;
      case (rdy_mode)
        2'd1:    tready_i = cyc[0];
        2'd2:    tready_i = ((cyc % 24) >= 20);
        default: tready_i = 1'b1;
      endcase
      if (pv && !pr)
        chk(tvalid_o && tdata_o == pd, "R8 hold", 32'(tdata_o), 32'(pd));
      if (phold)
        chk(!sclk_o, "R8 sclk parked", 32'(sclk_o), 32'd0);
      if (tvalid_o && tready_i) begin
        chk(tdata_o == fbyte(cur_addr, got), cur_quad ? "R5 x4 byte" : "R4 x1 byte",
            32'(tdata_o), 32'(fbyte(cur_addr, got)));
        got++;
      end
      if (cs_no) begin
        falls = 0;
        ncap  = 0;
        hi_len = 0;
      end else begin
        if (sclk_o && !psclk) begin
          if (ncap < 32) begin
            cmd_word = {cmd_word[30:0], dq0_o};
            ncap++;
          end
          hi_len = 1;
        end else if (sclk_o) begin
          hi_len++;
        end
        if (!sclk_o && psclk) begin
          if (hi_len != exp_half) hi_bad++;
          falls++;
          if (falls >= 32) dq_i = unit_val(cur_quad, cur_addr, falls - 32);
        end
      end
      if (done_o) done_cnt++;
      pv = tvalid_o;
      pr = tready_i;
      pd = tdata_o;
      phold = tvalid_o && !tready_i && !sclk_o;
      psclk = sclk_o;
    end
  endtask

  task automatic run_vec(input vec_t v, input bit inject);
    quad_i = v.quad; clk_src_i = v.src; start_addr_i = v.addr; byte_count_i = 16'(v.nb);
    cur_quad = v.quad; cur_addr = v.addr; rdy_mode = v.rdy;
    exp_half = v.src ? 3 : 2;  // R3: DIV_USR=6, DIV_INT=4
    got = 0; done_cnt = 0; hi_bad = 0; cmd_word = '0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (inject) begin
      repeat (60) @(negedge clk);
      start_i = 1'b1; quad_i = ~v.quad; clk_src_i = ~v.src;
      start_addr_i = ~v.addr; byte_count_i = 16'd1;
      @(negedge clk); start_i = 1'b0;
    end
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done_cnt > 0 && got == int'(v.nb)) break;
    end
    repeat (5) @(negedge clk);
    chk(cmd_word == {8'h03, v.addr}, "R2 command", cmd_word, {8'h03, v.addr});
    chk(got == int'(v.nb), "R7 byte total", 32'(got), 32'(v.nb));
    chk(done_cnt == 1, "R7 done pulses", 32'(done_cnt), 32'd1);
    chk(hi_bad == 0, "R3 high phase", 32'(hi_bad), 32'd0);
    chk(cs_no && !sclk_o, "R7 idle after end", {30'd0, cs_no, sclk_o}, 32'h2);
    if (inject)
      chk(got == int'(v.nb) && cmd_word == {8'h03, v.addr}, "R6 busy start ignored",
          32'(got), 32'(v.nb));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    fork monitor(); join_none
    repeat (3) @(negedge clk);
    chk(cs_no && !sclk_o && !tvalid_o && !done_o, "R1 reset state",
        {28'd0, cs_no, sclk_o, tvalid_o, done_o}, 32'h8);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_no && !sclk_o, "R3 idle clock low", {30'd0, cs_no, sclk_o}, 32'h2);

    for (int k = 0; k < 6; k++) run_vec(VECS[k], 1'b0);

    // R6: second start with different settings mid-transfer
    run_vec('{1'b0, 1'b0, 24'h3C3C3C, 8'd6, 2'd0}, 1'b1);
    // R7: zero byte count
    run_vec('{1'b1, 1'b0, 24'h000010, 8'd0, 2'd0}, 1'b0);
    // R8: x1 with heavy stall on user ratio
    run_vec('{1'b0, 1'b1, 24'h55AA55, 8'd7, 2'd2}, 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule